// File: doc/BRIEF.md
# Operand Address Calculator for Register-Indirect Modes

This block turns an operand specifier into a memory address. It takes a 3-bit addressing mode, an address register number and its contents, the operand size, an index value and an optional 16-bit extension word. From these it produces the effective address. For the auto-stepping modes it also produces the new value of the address register. The register-direct modes are reported as register operands, so no memory access is started for them.

The block sits between operand decode and the load/store stage of an integer core. In the cycle a request is presented, it shows which index register the extension word names, so the surrounding register file can supply that register's value in the same cycle. All results are registered and appear one clock after the request. Indexed addressing is limited on purpose: it accepts only full-width index registers and scale factors of one, two and four. Any other extension-word encoding is reported as an address error, and that error blocks the register writeback.

Top module: `ea_gen`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `out_valid`, `out_is_reg`, `out_wb_en`, `out_err`, `out_ea`, `out_wb_val` and `out_wb_reg` are all zero.
- R2: Every output except `idx_reg` is registered, with one cycle of latency. `out_valid` equals `req_valid` of the previous cycle. A cycle with `req_valid` low leaves all registered outputs at zero in the next cycle.
- R3: Mode 3'b000 (data register) and mode 3'b001 (address register) set `out_is_reg`. Both return `out_ea` = 0 with no writeback and no error.
- R4: Mode 3'b010 returns the address register value as `out_ea` and does not request a writeback.
- R5: Mode 3'b011 returns the register value as `out_ea`. It sets `out_wb_en` and returns `out_wb_val` = register + step. The step is 1, 2 or 4 for `op_size` 2'b00 (byte), 2'b01 (word) or 2'b10 (long), and `op_size` 2'b11 also steps by 4.
- R6: Mode 3'b100 subtracts the same step from the register value. It returns the result as both `out_ea` and `out_wb_val`, and sets `out_wb_en`.
- R7: Register number 7, the stack pointer, is stepped exactly like every other register. `out_wb_reg` returns the register number of the request.
- R8: Mode 3'b101 returns register + sign-extended `ext_word`, with no writeback.
- R9: `idx_reg` is combinational and equals {`ext_word[15]`, `ext_word[14:12]`}. Bit 3 selects the register kind (0 = data, 1 = address) and bits 2:0 give the register number.
- R10: Mode 3'b110 returns register + sign-extended `ext_word[7:0]` + (`idx_val` shifted left by `ext_word[10:9]`), with no writeback. Scale code 00 multiplies by 1, 01 by 2 and 10 by 4.
- R11: In mode 3'b110 the block sets `out_err`, clears `out_wb_en` and returns `out_ea` = 0 in three cases: `ext_word[11]` is 0 (word-sized index), `ext_word[10:9]` is 11, or `ext_word[8]` is 1.
- R12: Mode 3'b111 is not handled here. It sets `out_err`, with `out_ea` = 0 and no writeback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| mode | input | 3 | Addressing mode field |
| reg_num | input | 3 | Base address register number |
| op_size | input | 2 | Operand size: 00 byte, 01 word, 10/11 long |
| areg_val | input | ADDR_W | Contents of the base address register |
| idx_val | input | ADDR_W | Contents of the index register named by `idx_reg` |
| ext_word | input | 16 | Extension word |
| idx_reg | output | 4 | Index register select {kind, number} |
| out_valid | output | 1 | Result valid |
| out_ea | output | ADDR_W | Effective address |
| out_is_reg | output | 1 | Operand is a register, not memory |
| out_wb_en | output | 1 | Base register must be updated |
| out_wb_val | output | ADDR_W | New base register value |
| out_wb_reg | output | 3 | Register to update |
| out_err | output | 1 | Address error |

## Verification
Every result register is loaded from the request of the previous cycle and is never held over, so a wrong stored value is visible at the ports one cycle after the request that produced it. The step adder and the extension-word checker are the most likely sources of silent damage. A wrong step shows up as an `out_wb_val` that is off by a few bytes, or as an `out_ea` that differs from `out_wb_val` in predecrement mode. A lost error term shows up as a nonzero address or a raised writeback on a malformed extension word. The directed cases drive each size and each reserved field separately, so each of these faults reaches the outputs on its own request.

// File: rtl/ea_gen_pkg.sv
`timescale 1ns/1ps
package ea_gen_pkg;

    typedef enum logic [2:0] {
        EA_DREG    = 3'b000,
        EA_AREG    = 3'b001,
        EA_IND     = 3'b010,
        EA_POSTINC = 3'b011,
        EA_PREDEC  = 3'b100,
        EA_DISP    = 3'b101,
        EA_INDEX   = 3'b110,
        EA_RSVD    = 3'b111
    } ea_mode_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_WORD = 2'b01,
        SZ_LONG = 2'b10,
        SZ_ALT  = 2'b11
    } op_size_e;

    // Extension word layout, msb first
    typedef struct packed {
        logic       idx_is_addr;
        logic [2:0] idx_num;
        logic       idx_long;
        logic [1:0] scale;
        logic       rsvd;
        logic [7:0] disp;
    } ext_fields_t;

    localparam logic [1:0] SCALE_BAD = 2'b11;

    function automatic logic [2:0] step_of(input logic [1:0] sz);
        case (sz)
            SZ_BYTE: step_of = 3'd1;
            SZ_WORD: step_of = 3'd2;
            default: step_of = 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/ea_ext_decode.sv
`timescale 1ns/1ps
module ea_ext_decode
    import ea_gen_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [15:0]       ext_word,
    output ext_fields_t       fields,
    output logic              fmt_err,
    output logic [ADDR_W-1:0] disp8_sx,
    output logic [ADDR_W-1:0] disp16_sx
);
    assign fields    = ext_fields_t'(ext_word);
    assign disp8_sx  = {{(ADDR_W-8){fields.disp[7]}}, fields.disp};
    assign disp16_sx = {{(ADDR_W-16){ext_word[15]}}, ext_word};

    always_comb begin
        fmt_err = 1'b0;
        if (!fields.idx_long)         fmt_err = 1'b1;
        if (fields.scale == SCALE_BAD) fmt_err = 1'b1;
        if (fields.rsvd)              fmt_err = 1'b1;
    end
endmodule

// File: rtl/ea_index_scale.sv
`timescale 1ns/1ps
module ea_index_scale #(
    parameter int ADDR_W   = 32,
    parameter int MAX_SHIFT = 2
) (
    input  logic [ADDR_W-1:0] idx_val,
    input  logic [1:0]        scale,
    output logic [ADDR_W-1:0] scaled
);
    localparam int NSEL = MAX_SHIFT + 1;
    logic [ADDR_W-1:0] shifted [NSEL];

    for (genvar s = 0; s < NSEL; s++) begin : g_shift
        assign shifted[s] = idx_val << s;
    end

    always_comb begin
        scaled = shifted[0];
        for (int s = 1; s < NSEL; s++) begin
            if (int'(scale) == s) scaled = shifted[s];
        end
    end
endmodule

// File: rtl/ea_step_adjust.sv
`timescale 1ns/1ps
module ea_step_adjust
    import ea_gen_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [1:0]        size,
    output logic [ADDR_W-1:0] inc_val,
    output logic [ADDR_W-1:0] dec_val
);
    logic [ADDR_W-1:0] step;
    assign step    = {{(ADDR_W-3){1'b0}}, step_of(size)};
    assign inc_val = base + step;
    assign dec_val = base - step;
endmodule

// File: rtl/ea_gen.sv
`timescale 1ns/1ps
module ea_gen
    import ea_gen_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [2:0]        mode,
    input  logic [2:0]        reg_num,
    input  logic [1:0]        op_size,
    input  logic [ADDR_W-1:0] areg_val,
    input  logic [ADDR_W-1:0] idx_val,
    input  logic [15:0]       ext_word,
    output logic [3:0]        idx_reg,
    output logic              out_valid,
    output logic [ADDR_W-1:0] out_ea,
    output logic              out_is_reg,
    output logic              out_wb_en,
    output logic [ADDR_W-1:0] out_wb_val,
    output logic [2:0]        out_wb_reg,
    output logic              out_err
);
    ext_fields_t       fields;
    logic              fmt_err;
    logic [ADDR_W-1:0] disp8_sx, disp16_sx, idx_scaled, inc_val, dec_val;

    ea_ext_decode #(.ADDR_W(ADDR_W)) u_ext (
        .ext_word (ext_word),
        .fields   (fields),
        .fmt_err  (fmt_err),
        .disp8_sx (disp8_sx),
        .disp16_sx(disp16_sx)
    );

    ea_index_scale #(.ADDR_W(ADDR_W), .MAX_SHIFT(2)) u_scale (
        .idx_val(idx_val),
        .scale  (fields.scale),
        .scaled (idx_scaled)
    );

    ea_step_adjust #(.ADDR_W(ADDR_W)) u_step (
        .base   (areg_val),
        .size   (op_size),
        .inc_val(inc_val),
        .dec_val(dec_val)
    );

    assign idx_reg = {fields.idx_is_addr, fields.idx_num};

    ea_mode_e          mode_e;
    logic [ADDR_W-1:0] nxt_ea, nxt_wb_val;
    logic              nxt_is_reg, nxt_wb_en, nxt_err;

    assign mode_e = ea_mode_e'(mode);

    always_comb begin
        nxt_ea     = '0;
        nxt_wb_val = '0;
        nxt_is_reg = 1'b0;
        nxt_wb_en  = 1'b0;
        nxt_err    = 1'b0;
        if (req_valid) begin
            case (mode_e)
                EA_DREG, EA_AREG: nxt_is_reg = 1'b1;
                EA_IND:           nxt_ea = areg_val;
                EA_POSTINC: begin
                    nxt_ea     = areg_val;
                    nxt_wb_val = inc_val;
                    nxt_wb_en  = 1'b1;
                end
                EA_PREDEC: begin
                    nxt_ea     = dec_val;
                    nxt_wb_val = dec_val;
                    nxt_wb_en  = 1'b1;
                end
                EA_DISP:          nxt_ea = areg_val + disp16_sx;
                EA_INDEX: begin
                    if (fmt_err) nxt_err = 1'b1;
                    else         nxt_ea  = areg_val + disp8_sx + idx_scaled;
                end
                default:          nxt_err = 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            out_ea     <= '0;
            out_is_reg <= 1'b0;
            out_wb_en  <= 1'b0;
            out_wb_val <= '0;
            out_wb_reg <= '0;
            out_err    <= 1'b0;
        end else begin
            out_valid  <= req_valid;
            out_ea     <= nxt_ea;
            out_is_reg <= nxt_is_reg;
            out_wb_en  <= nxt_wb_en;
            out_wb_val <= nxt_wb_val;
            out_wb_reg <= req_valid ? reg_num : 3'd0;
            out_err    <= nxt_err;
        end
    end

    // R11
    err_blocks_wb_chk: assert property (@(posedge clk) disable iff (rst)
        out_err |-> (!out_wb_en && out_ea == '0));

    // R3
    reg_operand_chk: assert property (@(posedge clk) disable iff (rst)
        out_is_reg |-> (!out_wb_en && !out_err && out_ea == '0));

    // R2
    latency_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> out_valid);

    // R5
    postinc_step_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && mode == EA_POSTINC) |=>
            (out_wb_en && out_ea == $past(areg_val)
             && out_wb_val == out_ea + ADDR_W'(step_of($past(op_size)))));

    // R6
    predec_step_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && mode == EA_PREDEC) |=>
            (out_wb_en && out_wb_val == out_ea
             && out_ea == $past(areg_val) - ADDR_W'(step_of($past(op_size)))));

    // R12
    rsvd_mode_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && mode == EA_RSVD) |=> out_err);
endmodule

// File: tb/ea_gen_tb.sv
`timescale 1ns/1ps
module ea_gen_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [2:0]  mode = '0;
    logic [2:0]  reg_num = '0;
    logic [1:0]  op_size = '0;
    logic [31:0] areg_val = '0;
    logic [31:0] idx_val = '0;
    logic [15:0] ext_word = '0;
    logic [3:0]  idx_reg;
    logic        out_valid, out_is_reg, out_wb_en, out_err;
    logic [31:0] out_ea, out_wb_val;
    logic [2:0]  out_wb_reg;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    ea_gen #(.ADDR_W(32)) u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .mode(mode),
        .reg_num(reg_num), .op_size(op_size), .areg_val(areg_val),
        .idx_val(idx_val), .ext_word(ext_word), .idx_reg(idx_reg),
        .out_valid(out_valid), .out_ea(out_ea), .out_is_reg(out_is_reg),
        .out_wb_en(out_wb_en), .out_wb_val(out_wb_val),
        .out_wb_reg(out_wb_reg), .out_err(out_err)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // drive at negedge, result registered at next posedge, sample at following negedge
    task automatic issue(input logic [2:0] m, input logic [2:0] r, input logic [1:0] sz,
                         input logic [31:0] a, input logic [31:0] ix, input logic [15:0] ew);
        req_valid = 1'b1; mode = m; reg_num = r; op_size = sz;
        areg_val = a; idx_val = ix; ext_word = ew;
        @(posedge clk); @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic expect_out(input string req, input logic [31:0] ea, input logic wb,
                              input logic [31:0] wbv, input logic isr, input logic err);
        check({req, " valid"}, 32'(out_valid), 32'd1);
        check({req, " ea"}, out_ea, ea);
        check({req, " wb_en"}, 32'(out_wb_en), 32'(wb));
        if (wb) check({req, " wb_val"}, out_wb_val, wbv);
        check({req, " is_reg"}, 32'(out_is_reg), 32'(isr));
        check({req, " err"}, 32'(out_err), 32'(err));
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 valid", 32'(out_valid), 0);
        check("R1 ea", out_ea, 0);
        check("R1 wb", 32'(out_wb_en), 0);
        check("R1 err", 32'(out_err), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 post valid", 32'(out_valid), 0);
        check("R1 post wb_reg", 32'(out_wb_reg), 0);
    endtask

    task automatic t_reg_modes();
        issue(3'b000, 3'd2, 2'b10, 32'h1234_5678, 0, 0);
        expect_out("R3 dreg", 0, 0, 0, 1, 0);
        issue(3'b001, 3'd5, 2'b00, 32'hDEAD_BEEF, 0, 0);
        expect_out("R3 areg", 0, 0, 0, 1, 0);
    endtask

    task automatic t_indirect();
        issue(3'b010, 3'd1, 2'b01, 32'h0000_8000, 0, 0);
        expect_out("R4 ind", 32'h0000_8000, 0, 0, 0, 0);
    endtask

    task automatic t_postinc();
        issue(3'b011, 3'd3, 2'b00, 32'h0000_1000, 0, 0);
        expect_out("R5 byte", 32'h1000, 1, 32'h1001, 0, 0);
        issue(3'b011, 3'd3, 2'b01, 32'h0000_1000, 0, 0);
        expect_out("R5 word", 32'h1000, 1, 32'h1002, 0, 0);
        issue(3'b011, 3'd3, 2'b10, 32'hFFFF_FFFE, 0, 0);
        expect_out("R5 long wrap", 32'hFFFF_FFFE, 1, 32'h0000_0002, 0, 0);
        issue(3'b011, 3'd3, 2'b11, 32'h0000_0010, 0, 0);
        expect_out("R5 size11", 32'h10, 1, 32'h14, 0, 0);
    endtask

    task automatic t_predec();
        issue(3'b100, 3'd4, 2'b00, 32'h0000_2000, 0, 0);
        expect_out("R6 byte", 32'h1FFF, 1, 32'h1FFF, 0, 0);
        issue(3'b100, 3'd4, 2'b01, 32'h0000_2000, 0, 0);
        expect_out("R6 word", 32'h1FFE, 1, 32'h1FFE, 0, 0);
        issue(3'b100, 3'd4, 2'b10, 32'h0000_0002, 0, 0);
        expect_out("R6 long wrap", 32'hFFFF_FFFE, 1, 32'hFFFF_FFFE, 0, 0);
    endtask

    task automatic t_stack_ptr();
        issue(3'b100, 3'd7, 2'b00, 32'h0000_4000, 0, 0);
        expect_out("R7 sp predec byte", 32'h3FFF, 1, 32'h3FFF, 0, 0);
        check("R7 wb_reg", 32'(out_wb_reg), 7);
        issue(3'b011, 3'd7, 2'b00, 32'h0000_4000, 0, 0);
        expect_out("R7 sp postinc byte", 32'h4000, 1, 32'h4001, 0, 0);
    endtask

    task automatic t_disp16();
        issue(3'b101, 3'd0, 2'b10, 32'h0001_0000, 0, 16'h0100);
        expect_out("R8 pos", 32'h0001_0100, 0, 0, 0, 0);
        issue(3'b101, 3'd0, 2'b10, 32'h0001_0000, 0, 16'hFFF0);
        expect_out("R8 neg", 32'h0000_FFF0, 0, 0, 0, 0);
    endtask

    task automatic t_idx_sel();
        ext_word = 16'hD800;
        #1 check("R9 addr kind", 32'(idx_reg), 32'hD);
        ext_word = 16'h2800;
        #1 check("R9 data kind", 32'(idx_reg), 32'h2);
        @(negedge clk);
    endtask

    task automatic t_index();
        // long index, scale x1, disp +4
        issue(3'b110, 3'd1, 2'b10, 32'h0000_1000, 32'h0000_0010, 16'h0804);
        expect_out("R10 x1", 32'h1014, 0, 0, 0, 0);
        // scale x2, disp -2
        issue(3'b110, 3'd1, 2'b10, 32'h0000_1000, 32'h0000_0010, 16'h0AFE);
        expect_out("R10 x2", 32'h101E, 0, 0, 0, 0);
        // scale x4, negative index
        issue(3'b110, 3'd1, 2'b10, 32'h0000_1000, 32'hFFFF_FFFF, 16'h8C00);
        expect_out("R10 x4", 32'h0FFC, 0, 0, 0, 0);
    endtask

    task automatic t_index_errors();
        issue(3'b110, 3'd1, 2'b10, 32'h0000_1000, 32'h10, 16'h0004);
        expect_out("R11 word index", 0, 0, 0, 0, 1);
        issue(3'b110, 3'd1, 2'b10, 32'h0000_1000, 32'h10, 16'h0E04);
        expect_out("R11 scale 11", 0, 0, 0, 0, 1);
        issue(3'b110, 3'd1, 2'b10, 32'h0000_1000, 32'h10, 16'h0904);
        expect_out("R11 bit8", 0, 0, 0, 0, 1);
    endtask

    task automatic t_reserved();
        issue(3'b111, 3'd2, 2'b10, 32'h0000_1000, 0, 0);
        expect_out("R12 mode7", 0, 0, 0, 0, 1);
    endtask

    task automatic t_idle();
        issue(3'b011, 3'd6, 2'b10, 32'h0000_0100, 0, 0);
        @(posedge clk); @(negedge clk);
        check("R2 idle valid", 32'(out_valid), 0);
        check("R2 idle wb", 32'(out_wb_en), 0);
        check("R2 idle ea", out_ea, 0);
        check("R2 idle wb_reg", 32'(out_wb_reg), 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        t_reg_modes();
        t_indirect();
        t_postinc();
        t_predec();
        t_stack_ptr();
        t_disp16();
        t_idx_sel();
        t_index();
        t_index_errors();
        t_reserved();
        t_idle();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #50000;
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule